// File: doc/BRIEF.md
# Adaptive Age-Limited Prefetch Dropper

This block sits beside a memory request buffer and watches how long each queued prefetch has been waiting. Every buffer slot has a shadow record: whether the slot is live, whether it holds a prefetch, which core issued it, and an age counter. The age starts at zero when the slot is filled and goes up by one on every clock edge. Once a live prefetch is older than the age limit of its core, the block raises that slot's drop strobe for one cycle and clears the record. The request buffer then discards the request.

The age limit is not fixed. Each core supplies its measured prefetch accuracy as an integer percentage. That value picks one of four limits, and a less accurate core gets a shorter limit, so its stale prefetches are removed sooner. When a demand hits a queued prefetch, the buffer pulses that slot's promote line. The slot then counts as a demand and is never dropped. Freeing a slot stops tracking at once.

All inputs are single-cycle event strobes or steady levels, so there is no valid/ready handshake and no back-pressure. An allocate or free is taken on the edge where it is presented. Drop strobes are plain outputs with no hold-off: the request buffer must act on them in the cycle they appear. A running count of drops is kept for the surrounding logic.

Top module: `prefetch_dropper`

## Requirements
- R1: While reset is held, and after it is released with no allocations, all drop strobes are 0 and the drop count is 0.
- R2: The age limit T of a core comes from its accuracy value a, which is 7 bits and unsigned: a < 10 gives LIM0, 10 ≤ a < 30 gives LIM1, 30 ≤ a < 70 gives LIM2, and a ≥ 70 gives LIM3. A value exactly on an edge belongs to the higher band.
- R3: Suppose a prefetch is allocated on edge A (alloc_pf = 1), the slot is not touched again, and its core's accuracy stays constant. Then that slot's drop strobe is high in the cycle after edge A+T+1 and in no earlier cycle, where T is the limit of the issuing core.
- R4: A slot whose drop strobe is high becomes invalid on the next edge. It raises no further strobe until it is allocated again.
- R5: A slot allocated with alloc_pf = 0 (a demand) never raises a drop strobe, however long it waits.
- R6: A promote pulse on a live slot clears its prefetch status on that edge. The slot raises no drop strobe afterwards.
- R7: A free of a slot before its limit is reached ends tracking, and that slot raises no drop strobe.
- R8: On every edge the drop count grows by the number of drop strobes high in the cycle before, wrapping at its width. When two or more slots are dropped in the same cycle, each one is counted.
- R9: Each slot is judged against the limit of the core recorded for that slot at allocation, not against the limit of any other core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Fill a slot on this edge |
| alloc_idx | input | IDX_W | Slot being filled |
| alloc_pf | input | 1 | 1 = prefetch, 0 = demand |
| alloc_core | input | CORE_W | Issuing core of the new request |
| free_valid | input | 1 | Release a slot on this edge |
| free_idx | input | IDX_W | Slot being released |
| promote_vec | input | N_SLOTS | Per-slot demand-hit promotion pulse |
| core_acc | input | N_CORES*7 | Accuracy percentage of each core, core 0 in the low bits |
| drop_vec | output | N_SLOTS | Per-slot drop strobe |
| drop_count | output | CNT_W | Wrapping count of dropped prefetches |

## Verification
The bench sets each band edge (9/10, 29/30, 69/70) and the top value of 100, and checks that the drop lands in exactly the predicted cycle. A design that put an edge in the lower band, or compared with ≥ instead of >, would strobe one cycle early or use the wrong limit. Demand slots, promoted slots and freed slots are each left waiting well past their limit. A design that ignored the prefetch bit, the promotion or the free would show a strobe there. Two slots from different cores are timed to expire in the same cycle. A counter that added one per cycle instead of a population count would come out one short.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int ACC_W = 7;
  typedef logic [1:0] band_t;

  // Band selection; a value on an edge falls into the upper band.
  function automatic band_t band_of(input logic [ACC_W-1:0] acc,
                                    input int e1, input int e2, input int e3);
    if (int'(acc) < e1)      return 2'd0;
    else if (int'(acc) < e2) return 2'd1;
    else if (int'(acc) < e3) return 2'd2;
    else                     return 2'd3;
  endfunction
endpackage

// File: rtl/pfd_limit_table.sv
module pfd_limit_table
  import pfd_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int LIM_W   = 17,
  parameter int LIM0    = 100,
  parameter int LIM1    = 1500,
  parameter int LIM2    = 50000,
  parameter int LIM3    = 100000,
  parameter int EDGE1   = 10,
  parameter int EDGE2   = 30,
  parameter int EDGE3   = 70
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_CORES*ACC_W-1:0]   acc_flat,
  output logic [N_CORES*LIM_W-1:0]   lim_flat
);
  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    logic [ACC_W-1:0] acc_c;
    band_t            band_c;
    assign acc_c  = acc_flat[c*ACC_W +: ACC_W];
    assign band_c = band_of(acc_c, EDGE1, EDGE2, EDGE3);
    always_comb begin
      unique case (band_c)
        2'd0:    lim_flat[c*LIM_W +: LIM_W] = LIM_W'(LIM0);
        2'd1:    lim_flat[c*LIM_W +: LIM_W] = LIM_W'(LIM1);
        2'd2:    lim_flat[c*LIM_W +: LIM_W] = LIM_W'(LIM2);
        default: lim_flat[c*LIM_W +: LIM_W] = LIM_W'(LIM3);
      endcase
    end
  end

  // R2: a less accurate core never receives a longer limit
  if (N_CORES > 1) begin : g_order
    a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_flat[0 +: ACC_W] < acc_flat[ACC_W +: ACC_W]) |->
      (lim_flat[0 +: LIM_W] <= lim_flat[LIM_W +: LIM_W]));
  end
endmodule

// File: rtl/pfd_slot.sv
module pfd_slot #(
  parameter int N_CORES = 4,
  parameter int CORE_W  = 2,
  parameter int AGE_W   = 17
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_hit,
  input  logic                      alloc_pf,
  input  logic [CORE_W-1:0]         alloc_core,
  input  logic                      free_hit,
  input  logic                      promote,
  input  logic [N_CORES*AGE_W-1:0]  lim_flat,
  output logic                      drop_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic              valid_q, pf_q;
  logic [CORE_W-1:0] core_q;
  logic [AGE_W-1:0]  age_q;
  logic [AGE_W-1:0]  lim_sel;

  always_comb begin
    lim_sel = '0;
    for (int c = 0; c < N_CORES; c++)
      if (core_q == CORE_W'(c)) lim_sel = lim_flat[c*AGE_W +: AGE_W];
  end

  assign drop_o = valid_q && pf_q && (age_q > lim_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pf_q    <= 1'b0;
      core_q  <= '0;
      age_q   <= '0;
    end else if (alloc_hit) begin
      valid_q <= 1'b1;
      pf_q    <= alloc_pf;
      core_q  <= alloc_core;
      age_q   <= '0;
    end else if (free_hit || drop_o) begin
      valid_q <= 1'b0;
      pf_q    <= 1'b0;
    end else if (valid_q) begin
      if (age_q != AGE_MAX) age_q <= age_q + 1'b1;
      if (promote) pf_q <= 1'b0;
    end
  end

  // R4: the slot is cleared right after its strobe and strobes once
  a_r4_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o && !alloc_hit |=> !valid_q);
  a_r4_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o && !alloc_hit |=> !drop_o);
  // R5: a freshly filled demand is not dropped
  a_r5_demand: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_hit && !alloc_pf |=> !drop_o);
  // R6: promotion removes the slot from dropping
  a_r6_promote: assert property (@(posedge clk) disable iff (!rst_n)
    promote && valid_q && !alloc_hit |=> !drop_o);
  // R7: a freed slot produces no strobe next cycle
  a_r7_free: assert property (@(posedge clk) disable iff (!rst_n)
    free_hit && !alloc_hit |=> !drop_o);
endmodule

// File: rtl/pfd_drop_tally.sv
module pfd_drop_tally #(
  parameter int N_SLOTS = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] drop_vec,
  output logic [CNT_W-1:0]   count_o
);
  localparam int POP_W = $clog2(N_SLOTS + 1);

  logic [POP_W-1:0] pop;

  always_comb begin
    pop = '0;
    for (int i = 0; i < N_SLOTS; i++) pop = pop + POP_W'(drop_vec[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_o <= '0;
    else        count_o <= count_o + CNT_W'(pop);
  end

  // R8: count moves exactly when drops occurred
  a_r8_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (|drop_vec) |=> (count_o != $past(count_o)));
  a_r8_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(|drop_vec) |=> $stable(count_o));
endmodule

// File: rtl/prefetch_dropper.sv
module prefetch_dropper
  import pfd_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int N_CORES = 4,
  parameter int CNT_W   = 16,
  parameter int LIM0    = 100,
  parameter int LIM1    = 1500,
  parameter int LIM2    = 50000,
  parameter int LIM3    = 100000,
  parameter int EDGE1   = 10,
  parameter int EDGE2   = 30,
  parameter int EDGE3   = 70,
  localparam int IDX_W  = $clog2(N_SLOTS),
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int AGE_W  = $clog2(LIM3 + 2)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_valid,
  input  logic [IDX_W-1:0]         alloc_idx,
  input  logic                     alloc_pf,
  input  logic [CORE_W-1:0]        alloc_core,
  input  logic                     free_valid,
  input  logic [IDX_W-1:0]         free_idx,
  input  logic [N_SLOTS-1:0]       promote_vec,
  input  logic [N_CORES*ACC_W-1:0] core_acc,
  output logic [N_SLOTS-1:0]       drop_vec,
  output logic [CNT_W-1:0]         drop_count
);
  logic [N_CORES*AGE_W-1:0] lim_flat;

  pfd_limit_table #(
    .N_CORES(N_CORES), .LIM_W(AGE_W),
    .LIM0(LIM0), .LIM1(LIM1), .LIM2(LIM2), .LIM3(LIM3),
    .EDGE1(EDGE1), .EDGE2(EDGE2), .EDGE3(EDGE3)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .acc_flat(core_acc), .lim_flat(lim_flat)
  );

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic a_hit, f_hit;
    assign a_hit = alloc_valid && (alloc_idx == IDX_W'(s));
    assign f_hit = free_valid  && (free_idx  == IDX_W'(s));
    pfd_slot #(.N_CORES(N_CORES), .CORE_W(CORE_W), .AGE_W(AGE_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc_hit(a_hit), .alloc_pf(alloc_pf), .alloc_core(alloc_core),
      .free_hit(f_hit), .promote(promote_vec[s]),
      .lim_flat(lim_flat), .drop_o(drop_vec[s])
    );
  end

  pfd_drop_tally #(.N_SLOTS(N_SLOTS), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .drop_vec(drop_vec), .count_o(drop_count)
  );

  // R1: nothing is dropped in the cycle right after reset
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (drop_vec == '0));
endmodule

// File: tb/prefetch_dropper_bench.sv
module prefetch_dropper_bench;
  localparam int NS = 8, NC = 4, CW = 16;
  localparam int T0 = 6, T1 = 14, T2 = 25, T3 = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 1'b0, alloc_pf = 1'b0, free_valid = 1'b0;
  logic [2:0] alloc_idx = '0, free_idx = '0;
  logic [1:0] alloc_core = '0;
  logic [NS-1:0] promote_vec = '0;
  logic [NC*7-1:0] core_acc = '0;
  logic [NS-1:0] drop_vec;
  logic [CW-1:0] drop_count;

  prefetch_dropper #(.N_SLOTS(NS), .N_CORES(NC), .CNT_W(CW),
    .LIM0(T0), .LIM1(T1), .LIM2(T2), .LIM3(T3)) u_prefetch_dropper (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
    .alloc_pf(alloc_pf), .alloc_core(alloc_core), .free_valid(free_valid),
    .free_idx(free_idx), .promote_vec(promote_vec), .core_acc(core_acc),
    .drop_vec(drop_vec), .drop_count(drop_count));

  always #10 clk = ~clk;  // 50 MHz

  typedef struct { int idx; int cyc; } exp_t;
  exp_t sb[$];
  int cyc = 0, checks = 0, errors = 0, total = 0;
  int nseen[NS];
  int last_cyc[NS];
  bit mon_on = 0, done = 0;
  logic [NS-1:0] e;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int lim_for(input int a);
    if (a < 10) return T0;
    if (a < 30) return T1;
    if (a < 70) return T2;
    return T3;
  endfunction

  task automatic set_acc(input int core, input int a);
    core_acc[core*7 +: 7] = 7'(a);
  endtask

  task automatic alloc(input int idx, input int core, input bit pf, output int a_cyc);
    @(negedge clk); #1;
    alloc_valid = 1; alloc_idx = 3'(idx); alloc_core = 2'(core); alloc_pf = pf;
    @(posedge clk); #1;
    alloc_valid = 0;
    a_cyc = cyc;
    for (int k = sb.size() - 1; k >= 0; k--) if (sb[k].idx == idx) sb.delete(k);
    if (pf) sb.push_back('{idx, a_cyc + lim_for(int'(core_acc[core*7 +: 7])) + 1});
  endtask

  task automatic unqueue(input int idx);
    for (int k = sb.size() - 1; k >= 0; k--) if (sb[k].idx == idx) sb.delete(k);
  endtask

  task automatic promote(input int idx);
    @(negedge clk); #1;
    promote_vec[idx] = 1'b1;
    @(posedge clk); #1;
    promote_vec = '0;
    unqueue(idx);
  endtask

  task automatic free_slot(input int idx);
    @(negedge clk); #1;
    free_valid = 1; free_idx = 3'(idx);
    @(posedge clk); #1;
    free_valid = 0;
    unqueue(idx);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: compares each cycle's strobes against the scoreboard (R3, R4)
  always @(negedge clk) begin
    if (mon_on) begin
      e = '0;
      foreach (sb[k]) if (sb[k].cyc == cyc) e[sb[k].idx] = 1'b1;
      for (int k = sb.size() - 1; k >= 0; k--) if (sb[k].cyc <= cyc) sb.delete(k);
      check(drop_vec === e, "R3/R4 drop_vec", drop_vec, e);
      for (int i = 0; i < NS; i++) if (drop_vec[i]) begin
        nseen[i]++; last_cyc[i] = cyc; total++;
      end
    end
  end

  initial begin
    int a, a0, a1;
    foreach (nseen[i]) begin nseen[i] = 0; last_cyc[i] = -1; end
    set_acc(0, 5); set_acc(1, 10); set_acc(2, 30); set_acc(3, 70);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(drop_vec == '0, "R1 strobes in reset", drop_vec, 0);
    check(drop_count == '0, "R1 count in reset", drop_count, 0);
    rst_n = 1;
    idle(3);
    @(negedge clk);
    check(drop_vec == '0 && drop_count == '0, "R1 after reset", drop_count, 0);
    mon_on = 1;

    // R3/R9: one prefetch per core, each timed by its own core's limit
    for (int c = 0; c < 4; c++) alloc(c, c, 1'b1, a);
    idle(T3 + 10);
    for (int c = 0; c < 4; c++) check(nseen[c] == 1, "R4 single strobe per slot", nseen[c], 1);
    check(last_cyc[3] - last_cyc[0] == 3 + T3 - T0, "R9 per-core limit", last_cyc[3] - last_cyc[0], 3 + T3 - T0);
    check(drop_count == CW'(total) && total == 4, "R8 count after four drops", drop_count, 4);

    // R5: demand slot waits far past every limit
    alloc(4, 0, 1'b0, a);
    idle(2 * T3);
    check(nseen[4] == 0, "R5 demand never dropped", nseen[4], 0);

    // R6: promoted prefetch
    alloc(5, 3, 1'b1, a);
    idle(T3 / 2);
    promote(5);
    idle(T3 + 10);
    check(nseen[5] == 0, "R6 promoted not dropped", nseen[5], 0);

    // R7: freed prefetch, then slot reused and dropped normally
    alloc(6, 2, 1'b1, a);
    idle(10);
    free_slot(6);
    idle(T2 + 10);
    check(nseen[6] == 0, "R7 freed not dropped", nseen[6], 0);
    alloc(6, 0, 1'b1, a);
    idle(T0 + 5);
    check(nseen[6] == 1 && last_cyc[6] == a + T0 + 1, "R7 reused slot drops", last_cyc[6], a + T0 + 1);

    // R2: band edges on core 0, slot 7
    foreach (e[i]) ;
    begin
      int vals[7] = '{9, 10, 29, 30, 69, 70, 100};
      foreach (vals[j]) begin
        set_acc(0, vals[j]);
        alloc(7, 0, 1'b1, a);
        idle(lim_for(vals[j]) + 5);
        check(last_cyc[7] == a + lim_for(vals[j]) + 1, "R2 band edge timing",
              last_cyc[7] - a - 1, lim_for(vals[j]));
      end
    end
    set_acc(0, 5);

    // R8: two slots from different cores expire in the same cycle
    alloc(0, 1, 1'b1, a0);
    idle(T1 - T0 - 1);
    alloc(1, 0, 1'b1, a1);
    idle(T1 + 5);
    check(last_cyc[0] == last_cyc[1], "R8 simultaneous drops", last_cyc[1], last_cyc[0]);
    check(drop_count == CW'(total) && total == 14, "R8 count with double drop", drop_count, 14);

    mon_on = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule